// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block connects an internal 32-bit master to an external data bus whose devices may be 8, 16 or 32 bits wide. The master presents one access at a time: an address, an operand size, a read/write flag and write data. The block then runs as many external cycles as the addressed device needs. Before each external cycle it samples a port-width input from the chip-select lookup. It places every operand byte on the external lane that matches its address and the port width. On reads it assembles the returned bytes into the operand and reports completion with a one-cycle pulse.

A strap input, sampled only while reset is held, sets the physical bus to 16 or 32 bits. With a 16-bit bus, the low half of the data bus carries no transfers, and a flag tells the rest of the chip that those lanes are free for general-purpose pins. Narrow devices always sit on the upper lanes. Sub-cycles run in big-endian order, lowest address first.

Top module: `bus_sizer`

## Requirements
- R1: `bus16_strap` is sampled only while `rst_n` is low. A sampled 1 selects a 16-bit physical bus. This raises `gpio_free`, treats any 32-bit port as 16 bits wide and leaves `ext_wdata[15:0]` at zero. A sampled 0 selects the full 32-bit bus with `gpio_free` low.
- R2: A request (`req_valid` high in a cycle with `busy` low) is accepted only when the block is idle. `busy` stays high from the cycle after acceptance until the final acknowledge. A `req_valid` raised while `busy` is high is ignored.
- R3: `port_width` is sampled once before each external cycle, not once per request. Its codes are 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. A width change between sub-cycles therefore changes how the remaining bytes are split.
- R4: Lane L (L = 0..3) of the external bus is `ext_wdata`/`ext_rdata` bits [31-8L:24-8L]. An 8-bit port uses lane 0 only, a 16-bit port lanes 0-1 and a 32-bit port lanes 0-3. Lanes not carrying data drive zero on writes.
- R5: Operand byte k (k = 0..3) is bits [31-8k:24-8k] of the operand. `req_size` 0 is a byte held in byte 3, 1 is a word held in bytes 2 (upper) and 3, and 2 or 3 is a longword in bytes 0..3.
- R6: Operand bytes go out in ascending address order, with the most significant byte present at the lowest address. The first byte of the operand lies at `req_addr` and each following byte one address higher.
- R7: A sub-cycle at address a to a port of P bytes uses lane (a mod P) for its first byte. It carries min(remaining bytes, P - (a mod P)) bytes, so a byte access to a 32-bit port uses the lane given by the two low address bits, and a misaligned access that crosses a port boundary splits.
- R8: Each sub-cycle keeps `ext_valid`, `ext_addr`, `ext_size`, `ext_write` and `ext_wdata` stable until `ext_ack` is sampled high. `ext_size` is the byte count of the sub-cycle minus one.
- R9: On reads, each acknowledged sub-cycle's lanes are stored into the matching operand bytes. `done` pulses for one cycle, the cycle after the final acknowledge, and `rdata` then holds the operand, with bytes outside the operand size reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus16_strap | input | 1 | Physical bus width strap, sampled during reset |
| req_valid | input | 1 | Internal access request |
| req_addr | input | AW | Byte address of the operand |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read operand |
| port_width | input | 2 | Width code of the addressed device |
| ext_valid | output | 1 | External cycle strobe |
| ext_addr | output | AW | External cycle address |
| ext_size | output | 2 | Bytes in the cycle minus one |
| ext_write | output | 1 | External cycle direction |
| ext_wdata | output | 32 | External write lanes |
| ext_rdata | input | 32 | External read lanes |
| ext_ack | input | 1 | Transfer acknowledge |
| gpio_free | output | 1 | Low lanes released for general-purpose use |

## Verification
The bench targets misaligned words and longwords that cross a port boundary. A design that ignored the boundary would drive a lane the device does not have, or issue the wrong number of cycles. It changes the port width between sub-cycles, which a design that latches the width once per request would split wrongly. It checks the strap at reset against 32-bit devices, where a design that ignored the strap would put data on the freed low lanes. It also raises a second request mid-sequence, which a design that failed to ignore it would let corrupt addresses or start a spurious cycle. The bench fills unused read lanes with a marker byte, so any wrong read lane shows up in the assembled operand.

// File: rtl/bus_sizer.sv
module bus_sizer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus16_strap,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rdata,
  input  logic [1:0]    port_width,
  output logic          ext_valid,
  output logic [AW-1:0] ext_addr,
  output logic [1:0]    ext_size,
  output logic          ext_write,
  output logic [31:0]   ext_wdata,
  input  logic [31:0]   ext_rdata,
  input  logic          ext_ack,
  output logic          gpio_free
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_ACT} st_t;

  st_t           st;
  logic          bus16_q, wr_q, done_q;
  logic [AW-1:0] base_q;
  logic [2:0]    n_q, sent_q;
  logic [1:0]    pw_q;
  logic [31:0]   wd_q, rbuf, rbuf_nx, wbus;

  logic [1:0] eff_pw;
  logic [2:0] pwb, room, rem, cnt, s_idx;
  logic [1:0] off;

  assign eff_pw   = port_width[1] ? (bus16_q ? 2'd1 : 2'd2) : port_width;
  assign ext_addr = base_q + AW'(sent_q);
  assign pwb      = 3'd1 << pw_q;
  assign off      = ext_addr[1:0] & 2'(pwb - 3'd1);
  assign room     = pwb - {1'b0, off};
  assign rem      = n_q - sent_q;
  assign cnt      = (rem < room) ? rem : room;
  assign s_idx    = 3'd4 - n_q;

  always_comb begin
    logic [1:0] ln, kk;
    wbus    = '0;
    rbuf_nx = rbuf;
    for (int j = 0; j < 4; j++) begin
      ln = off + 2'(j);
      kk = 2'(s_idx + sent_q) + 2'(j);
      if (3'(j) < cnt) begin
        wbus[{~ln, 3'b000} +: 8]    = wd_q[{~kk, 3'b000} +: 8];
        rbuf_nx[{~kk, 3'b000} +: 8] = ext_rdata[{~ln, 3'b000} +: 8];
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign rdata     = rbuf;
  assign ext_valid = (st == S_ACT);
  assign ext_size  = 2'(cnt - 3'd1);
  assign ext_write = wr_q;
  assign ext_wdata = (ext_valid && wr_q) ? wbus : '0;
  assign gpio_free = bus16_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bus16_q <= bus16_strap;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      base_q  <= '0;
      n_q     <= 3'd1;
      sent_q  <= '0;
      pw_q    <= '0;
      wd_q    <= '0;
      rbuf    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          base_q <= req_addr;
          n_q    <= (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
          sent_q <= '0;
          wr_q   <= req_write;
          wd_q   <= req_wdata;
          rbuf   <= '0;
          st     <= S_START;
        end
        S_START: begin
          pw_q <= eff_pw;
          st   <= S_ACT;
        end
        S_ACT: if (ext_ack) begin
          if (!wr_q) rbuf <= rbuf_nx;
          sent_q <= sent_q + cnt;
          if (sent_q + cnt == n_q) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_START;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module bus_sizer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          ext_valid,
  input logic          ext_ack,
  input logic [AW-1:0] ext_addr,
  input logic [1:0]    ext_size,
  input logic [31:0]   ext_wdata,
  input logic          gpio_free
);
  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(gpio_free));
  // R1
  low_lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_free && ext_valid) |-> (ext_wdata[15:0] == 16'h0 && ext_size <= 2'd1));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
  // R2
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> busy);
  // R8
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && !ext_ack) |=> (ext_valid && $stable(ext_addr) && $stable(ext_size) && $stable(ext_wdata)));
  // R9
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ext_ack) && !busy));
endmodule

bind bus_sizer bus_sizer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .ext_valid(ext_valid), .ext_ack(ext_ack), .ext_addr(ext_addr),
  .ext_size(ext_size), .ext_wdata(ext_wdata), .gpio_free(gpio_free)
);

// File: tb/sim_bus_sizer.sv
module sim_bus_sizer;
  logic clk = 0, rst_n = 0, bus16_strap = 0;
  logic req_valid = 0, req_write = 0, ext_ack = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, ext_rdata = 0;
  logic [1:0] req_size = 0, port_width = 0;
  logic busy, done, ext_valid, ext_write, gpio_free;
  logic [31:0] rdata, ext_addr, ext_wdata;
  logic [1:0] ext_size;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit b16 = 0, rnd_pw = 0, chkd = 0;
  int r_n = 1, r_s = 3, b_sent = 0, dly = 0;
  logic [31:0] r_addr = 0, r_wd = 0;
  bit r_wr = 0;

  always #10 clk = ~clk;

  bus_sizer u0 (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(logic [31:0] a);
    return (a[7:0] * 8'd37) ^ 8'hC3;
  endfunction

  function automatic int pbytes(logic [1:0] c, bit s16);
    if (c[1]) return s16 ? 2 : 4;
    return c == 0 ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // external device model and per-cycle checks
  always @(negedge clk) begin
    if (rst_n && ext_valid && !ext_ack) begin
      int pb, off, cnt;
      logic [31:0] ca, ew, rd;
      ca = r_addr + b_sent;
      pb = pbytes(port_width, b16);
      off = int'(ca) % pb;
      cnt = (r_n - b_sent < pb - off) ? r_n - b_sent : pb - off;
      if (!chkd) begin
        ew = 0;
        if (r_wr)
          for (int j = 0; j < cnt; j++)
            ew[8*(3-(off+j)) +: 8] = r_wd[8*(3-(r_s+b_sent+j)) +: 8];
        chk(busy == 1, "R2 busy in sequence", {31'b0, busy}, 1);
        chk(ext_addr == ca, "R6 sub-cycle address", ext_addr, ca);
        chk(ext_size == 2'(cnt - 1), "R7/R8 sub-cycle size", {30'b0, ext_size}, cnt - 1);
        chk(ext_write == r_wr, "R8 direction", {31'b0, ext_write}, {31'b0, r_wr});
        if (r_wr) chk(ext_wdata == ew, "R4/R5 write lanes", ext_wdata, ew);
        chkd = 1;
        dly = $urandom % 3;
      end
      if (dly == 0) begin
        rd = 32'hEEEE_EEEE;
        for (int l = 0; l < pb; l++) rd[8*(3-l) +: 8] = mem(ca - off + l);
        ext_rdata = rd;
        ext_ack = 1;
        b_sent += cnt;
        chkd = 0;
        if (rnd_pw) port_width = 2'($urandom % 4);
      end else dly--;
    end else ext_ack = 0;
  end

  task automatic do_req(logic [31:0] a, logic [1:0] sz, bit wr, logic [31:0] wd, logic [1:0] pw, bit rp);
    logic [31:0] exp;
    int t;
    @(negedge clk);
    port_width = pw; rnd_pw = rp;
    r_addr = a; r_n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4; r_s = 4 - r_n;
    r_wd = wd; r_wr = wr; b_sent = 0; chkd = 0;
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    chk(done == 1, "R9 done pulse", {31'b0, done}, 1);
    chk(b_sent == r_n, "R6 bytes transferred", b_sent, r_n);
    chk(busy == 0, "R2 idle at done", {31'b0, busy}, 0);
    if (!wr) begin
      exp = 0;
      for (int i = 0; i < r_n; i++) exp[8*(3-(r_s+i)) +: 8] = mem(a + i);
      chk(rdata == exp, "R9/R5 read operand", rdata, exp);
    end
    @(negedge clk);
    chk(done == 0, "R9 done one cycle", {31'b0, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && ext_valid == 0, "R2 reset idle", {29'b0, busy, done, ext_valid}, 0);
    chk(gpio_free == 0, "R1 32-bit strap", {31'b0, gpio_free}, 0);
    // R7 byte to 32-bit port at each offset
    for (int o = 0; o < 4; o++) begin
      do_req(32'h100 + o, 0, 1, 32'hA1B2C3D4, 2, 0);
      do_req(32'h100 + o, 0, 0, 0, 2, 0);
    end
    do_req(32'h201, 1, 1, 32'h0000_5A6B, 2, 0);   // R7 word inside port
    do_req(32'h203, 1, 0, 0, 2, 0);               // R7 word crossing port
    do_req(32'h302, 2, 1, 32'h11223344, 1, 0);    // R6 long on 16-bit
    do_req(32'h300, 2, 0, 0, 0, 0);               // R6 long on 8-bit
    do_req(32'h401, 2, 0, 0, 3, 1);               // R3 width changes per cycle
    // R2 request during busy is ignored
    fork
      do_req(32'h500, 2, 1, 32'hCAFEF00D, 0, 0);
      begin
        repeat (3) @(negedge clk);
        req_addr = 32'h9990; req_valid = 1;
        @(negedge clk); req_valid = 0;
      end
    join
    repeat (4) @(negedge clk);
    chk(ext_valid == 0 && busy == 0, "R2 no spurious cycle", {30'b0, ext_valid, busy}, 0);
    for (int i = 0; i < 300; i++)
      do_req($urandom % 1024, 2'($urandom % 4), 1'($urandom % 2), $urandom,
             2'($urandom % 4), ($urandom % 4) == 0);
    // R1 16-bit strap
    @(negedge clk);
    rst_n = 0; bus16_strap = 1;
    repeat (2) @(negedge clk);
    rst_n = 1; bus16_strap = 0; b16 = 1;
    @(negedge clk);
    chk(gpio_free == 1, "R1 16-bit strap", {31'b0, gpio_free}, 1);
    do_req(32'h600, 2, 1, 32'h89ABCDEF, 2, 0);
    do_req(32'h601, 2, 0, 0, 3, 0);
    for (int i = 0; i < 100; i++)
      do_req($urandom % 1024, 2'($urandom % 4), 1'($urandom % 2), $urandom,
             2'($urandom % 4), ($urandom % 4) == 0);
    chk(gpio_free == 1, "R1 strap held", {31'b0, gpio_free}, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule